// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the row and column strobes of an asynchronous DRAM whenever the memory needs care that is not a data transfer. It covers the power-up pause, the initialisation cycles, periodic refresh, and entry into and exit from self-refresh. It shares the strobes with an access controller through a plain request/grant pair. The sequencer raises `bus_req` whenever it has work. It drives the strobes only after `bus_gnt` has been seen high in its idle state, and it drops `bus_req` the cycle after its last precharge. While `bus_req` is high, the access controller must keep `bus_gnt` high and must leave the strobes alone.

Every refresh and initialisation cycle is a column-before-row (CBR) cycle. The column strobes (both byte lanes together) fall first. The row strobe follows, and the column strobes rise a set number of cycles later. After the row strobe rises, a precharge gap follows. A pacer adds one owed refresh every `RFSH_INT` clocks. Owed refreshes that pile up while the bus is withheld are counted, up to a saturating limit. They are then issued back to back under a single grant. For self-refresh, the block holds both strobes low for at least `SR_MIN_CYC` clocks. On exit it holds the row strobe high for `SRX_CYC` clocks and then runs one catch-up CBR cycle. After that the pacer restarts.

If neither the sequencer nor the access controller (reported on `ctl_row_act`) has pulsed the row strobe for `IDLE_LIMIT` clocks, the memory is treated as uninitialised and the initialisation cycles run again. All durations are clock counts set by parameters.

Top module: `dram_rfsh_seq`

## Requirements
- R1: During reset and for the first `PWRUP_CYC` clocks after it, the strobes are high (`row_stb_n`=1, `col_stb_n`=2'b11), `init_done` is 0, and `bus_req` is 0; `bus_req` first rises on clock `PWRUP_CYC` after reset release.
- R2: After the pause, `INIT_CNT` CBR cycles run back to back under one grant, and `init_done` rises in the cycle after the last precharge, `PWRUP_CYC+1+INIT_CNT*(CSR_CYC+RAS_CYC+RP_CYC)` clocks after reset release.
- R3: Each CBR cycle has the following shape. `col_stb_n`=2'b00 for `CSR_CYC` clocks with the row strobe high. The row strobe then falls. The column strobes stay low for `CHR_CYC` clocks after that fall. The row strobe stays low for `RAS_CYC` clocks in total. The row strobe then stays high for at least `RP_CYC` clocks before the next fall.
- R4: Once `init_done` is high, one refresh becomes owed every `RFSH_INT` clocks, and `bus_req` rises `RFSH_INT` clocks after `init_done` rises.
- R5: The strobes leave their idle levels only while `bus_req` is high and after a grant, and `bus_req` falls in the cycle after the final precharge of a burst.
- R6: Owed refreshes accumulate while the grant is withheld, saturating at `2**OWED_W-1`, and are all issued back to back under one grant.
- R7: With `sr_req` high, `init_done` high and nothing owed, the block runs a CBR entry and then holds both strobes low with `sr_active` high. This lasts exactly `SR_MIN_CYC` clocks if `sr_req` drops early, and as long as `sr_req` stays high otherwise, with no other row-strobe fall.
- R8: On leaving self-refresh, both strobes stay high for `SRX_CYC` clocks. Exactly one catch-up CBR cycle follows under the same grant. The next refresh request comes `RFSH_INT` clocks after that cycle's column strobes fall.
- R9: If `IDLE_LIMIT` clocks pass without row-strobe activity while `init_done` is high, `init_done` falls and `INIT_CNT` initialisation cycles run again before `init_done` rises.
- R10: A pulse on `ctl_row_act` counts as row-strobe activity and restarts the inactivity count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| bus_gnt | input | 1 | Strobe ownership grant from the access controller |
| ctl_row_act | input | 1 | Access controller pulsed the row strobe this cycle |
| bus_req | output | 1 | Sequencer wants or holds the strobes |
| row_stb_n | output | 1 | Row strobe, active low |
| col_stb_n | output | 2 | Column strobes for both byte lanes, active low |
| init_done | output | 1 | Initialisation complete, normal access allowed |
| sr_active | output | 1 | Memory is held in self-refresh |

## Verification
The embedded properties check four rules on every clock:
- the column strobes fall before the row strobe in each CBR cycle, and rise before it outside self-refresh;
- the strobes never move without `bus_req`;
- self-refresh holds both strobes low and leaves with both high;
- the owed-refresh count moves by at most one per clock and saturates.

Only the bench scenarios can show the cycle-exact behaviour. That covers the power-up pause length, the count and timing of initialisation cycles, the pacing interval after initialisation and after self-refresh, the postponed-refresh bursts and their saturation, the minimum self-refresh hold, and re-initialisation after a long quiet period and its suppression by `ctl_row_act`.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    SQ_PWR,    // power-up pause
    SQ_IDLE,   // bus released, waiting for work and grant
    SQ_CSU,    // column strobes low, row strobe high
    SQ_HOLD,   // both strobes low
    SQ_RLOW,   // row low, column high
    SQ_PRE,    // precharge, both high
    SQ_SELF,   // self-refresh, both low
    SQ_SEXIT   // self-refresh exit precharge
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            tmr_q <= W'(RST_VAL);
    else if (load)         tmr_q <= load_val;
    else if (tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
  end

  assign expired = (tmr_q == '0);
endmodule

// File: rtl/rfsh_pacer.sv
module rfsh_pacer #(
  parameter int RFSH_INT = 1560,
  parameter int OWED_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              done,
  input  logic              load_one,
  output logic [OWED_W-1:0] owed
);
  localparam int CW = (RFSH_INT > 2) ? $clog2(RFSH_INT) : 1;
  localparam logic [OWED_W-1:0] OWED_MAX = '1;

  logic [CW-1:0]     cnt_q;
  logic [OWED_W-1:0] owed_q;
  logic              tick;

  assign tick = run && (cnt_q == CW'(RFSH_INT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      owed_q <= '0;
    end else if (load_one) begin
      cnt_q  <= '0;
      owed_q <= OWED_W'(1);
    end else begin
      if (run) cnt_q <= tick ? '0 : cnt_q + 1'b1;
      case ({tick, done})
        2'b10:   if (owed_q != OWED_MAX) owed_q <= owed_q + 1'b1;
        2'b01:   if (owed_q != '0)       owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  assign owed = owed_q;

  // R6: the owed count steps by at most one per clock
  a_r6_owed_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load_one |=> ((int'(owed_q) - int'($past(owed_q)) <= 1) &&
                   (int'($past(owed_q)) - int'(owed_q) <= 1)));

  // R6: a saturated count does not wrap
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_q == OWED_MAX && !done && !load_one) |=> owed_q == OWED_MAX);
endmodule

// File: rtl/idle_watch.sv
module idle_watch #(
  parameter int LIMIT = 800000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  output logic stale
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (activity)             cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
  end

  assign stale = (cnt_q == CW'(LIMIT));

  // R10: activity always clears the staleness flag
  a_r10_activity_clears: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !stale);
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int PWRUP_CYC  = 20000,
  parameter int INIT_CNT   = 8,
  parameter int RFSH_INT   = 1560,
  parameter int CSR_CYC    = 1,
  parameter int CHR_CYC    = 1,
  parameter int RAS_CYC    = 5,
  parameter int RP_CYC     = 3,
  parameter int SR_MIN_CYC = 10000,
  parameter int SRX_CYC    = 11,
  parameter int IDLE_LIMIT = 800000,
  parameter int OWED_W     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_req,
  input  logic       bus_gnt,
  input  logic       ctl_row_act,
  output logic       bus_req,
  output logic       row_stb_n,
  output logic [1:0] col_stb_n,
  output logic       init_done,
  output logic       sr_active
);
  localparam int MAXD = max_of(max_of(max_of(PWRUP_CYC, SR_MIN_CYC), max_of(RAS_CYC, RP_CYC)),
                               max_of(CSR_CYC, SRX_CYC));
  localparam int TW = $clog2(MAXD + 1);
  localparam int IW = $clog2(INIT_CNT + 1);

  seq_state_e        state_q, state_d;
  logic [IW-1:0]     init_left_q;
  logic              init_done_q, for_sr_q;
  logic              tmr_zero, tload;
  logic [TW-1:0]     tval;
  logic [OWED_W-1:0] owed;
  logic              stale, done_rf, load_one, pacer_run, activity;
  logic              work_init, work_rf, want_sr, req_idle, more;

  seq_timer #(.W(TW), .RST_VAL(PWRUP_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .expired(tmr_zero));

  assign pacer_run = init_done_q && (state_q != SQ_SELF) && (state_q != SQ_SEXIT);

  rfsh_pacer #(.RFSH_INT(RFSH_INT), .OWED_W(OWED_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(pacer_run), .done(done_rf),
    .load_one(load_one), .owed(owed));

  assign activity = !row_stb_n || ctl_row_act;

  idle_watch #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk(clk), .rst_n(rst_n), .activity(activity), .stale(stale));

  assign work_init = (init_left_q != '0);
  assign work_rf   = (owed != '0);
  assign want_sr   = sr_req && init_done_q && !work_init && !work_rf && !stale;
  assign req_idle  = work_init || work_rf || want_sr;
  assign more      = work_init ? ((init_left_q > IW'(1)) || work_rf)
                               : (owed > OWED_W'(1));

  always_comb begin
    state_d  = state_q;
    done_rf  = 1'b0;
    load_one = 1'b0;
    case (state_q)
      SQ_PWR:   if (tmr_zero) state_d = SQ_IDLE;
      SQ_IDLE:  if (req_idle && bus_gnt) state_d = SQ_CSU;
      SQ_CSU:   if (tmr_zero) state_d = for_sr_q ? SQ_SELF : SQ_HOLD;
      SQ_HOLD:  if (tmr_zero) state_d = SQ_RLOW;
      SQ_RLOW:  if (tmr_zero) state_d = SQ_PRE;
      SQ_PRE: begin
        if (tmr_zero) begin
          done_rf = !work_init;
          state_d = more ? SQ_CSU : SQ_IDLE;
        end
      end
      SQ_SELF:  if (tmr_zero && !sr_req) state_d = SQ_SEXIT;
      SQ_SEXIT: begin
        if (tmr_zero) begin
          load_one = 1'b1;
          state_d  = SQ_CSU;
        end
      end
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    tload = (state_d != state_q);
    case (state_d)
      SQ_CSU:   tval = TW'(CSR_CYC - 1);
      SQ_HOLD:  tval = TW'(CHR_CYC - 1);
      SQ_RLOW:  tval = TW'(RAS_CYC - CHR_CYC - 1);
      SQ_PRE:   tval = TW'(RP_CYC - 1);
      SQ_SELF:  tval = TW'(SR_MIN_CYC - 1);
      SQ_SEXIT: tval = TW'(SRX_CYC - 1);
      default:  tval = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SQ_PWR;
      init_left_q <= IW'(INIT_CNT);
      init_done_q <= 1'b0;
      for_sr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == SQ_IDLE && state_d == SQ_CSU) for_sr_q <= want_sr;
      if (state_q == SQ_SELF) for_sr_q <= 1'b0;
      if (state_q == SQ_PRE && tmr_zero && work_init) begin
        init_left_q <= init_left_q - 1'b1;
        if (init_left_q == IW'(1)) init_done_q <= 1'b1;
      end
      if (state_q == SQ_IDLE && state_d == SQ_IDLE && init_done_q && stale) begin
        init_done_q <= 1'b0;
        init_left_q <= IW'(INIT_CNT);
      end
    end
  end

  assign row_stb_n = !(state_q == SQ_HOLD || state_q == SQ_RLOW || state_q == SQ_SELF);
  assign col_stb_n = (state_q == SQ_CSU || state_q == SQ_HOLD || state_q == SQ_SELF)
                     ? 2'b00 : 2'b11;
  assign bus_req   = (state_q == SQ_IDLE) ? req_idle : (state_q != SQ_PWR);
  assign init_done = init_done_q;
  assign sr_active = (state_q == SQ_SELF);

  // R3: column strobes are already low when the row strobe falls
  a_r3_col_leads_row: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb_n) |-> $past(col_stb_n) == 2'b00);

  // R3: outside self-refresh the column strobes rise before the row strobe
  a_r3_col_rises_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(row_stb_n) && !$past(sr_active)) |-> $past(col_stb_n) == 2'b11);

  // R5: strobes move only while the bus is requested
  a_r5_strobes_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_stb_n || col_stb_n != 2'b11) |-> bus_req);

  // R7: self-refresh keeps both strobes low
  a_r7_self_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> (!row_stb_n && col_stb_n == 2'b00));

  // R8: self-refresh ends with both strobes high
  a_r8_exit_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_active) |-> (row_stb_n && col_stb_n == 2'b11));
endmodule

// File: tb/dram_rfsh_seq_tb.sv
module dram_rfsh_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PWRUP  = 30;
  localparam int INITN  = 8;
  localparam int RFSH   = 100;
  localparam int CSR    = 1;
  localparam int CHR    = 2;
  localparam int RAS    = 4;
  localparam int RP     = 2;
  localparam int SRMIN  = 50;
  localparam int SRX    = 3;
  localparam int IDLE   = 1000;
  localparam int OWEDW  = 2;
  localparam int CBR_LEN = CSR + RAS + RP;

  // {grant hold-off in refresh intervals, expected burst length}
  localparam int POSTPONE_TBL [4][2] = '{'{1, 1}, '{2, 2}, '{3, 3}, '{5, 3}};

  logic clk = 1'b0, rst_n = 1'b0, sr_req = 1'b0, bus_gnt = 1'b1, ctl_row_act = 1'b0;
  logic bus_req, row_stb_n, init_done, sr_active;
  logic [1:0] col_stb_n;

  int n_chk = 0, n_err = 0, cyc = 0;
  int rf_cnt, first_req_cyc, req_rise_cyc, init_rise_cyc, cas_fall_cyc;
  int csu_run, chr_run, ras_len, hi_len, last_hi;
  bit was_sr, p_row, p_req, p_init;
  logic [1:0] p_col;

  dram_rfsh_seq #(
    .PWRUP_CYC(PWRUP), .INIT_CNT(INITN), .RFSH_INT(RFSH), .CSR_CYC(CSR),
    .CHR_CYC(CHR), .RAS_CYC(RAS), .RP_CYC(RP), .SR_MIN_CYC(SRMIN),
    .SRX_CYC(SRX), .IDLE_LIMIT(IDLE), .OWED_W(OWEDW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .bus_gnt(bus_gnt),
    .ctl_row_act(ctl_row_act), .bus_req(bus_req), .row_stb_n(row_stb_n),
    .col_stb_n(col_stb_n), .init_done(init_done), .sr_active(sr_active));

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Waveform monitor: measures each CBR cycle at the ports
  always @(negedge clk) begin
    if (!rst_n) begin
      rf_cnt = 0; first_req_cyc = -1; req_rise_cyc = -1; init_rise_cyc = -1;
      cas_fall_cyc = -1; csu_run = 0; chr_run = 0; ras_len = 0; hi_len = 0;
      last_hi = 0; was_sr = 0; p_row = 1; p_req = 0; p_init = 0; p_col = 2'b11;
    end else begin
      if (bus_req && !p_req) begin
        req_rise_cyc = cyc;
        if (first_req_cyc < 0) first_req_cyc = cyc;
      end
      if (init_done && !p_init) init_rise_cyc = cyc;
      if (col_stb_n == 2'b00 && p_col == 2'b11) cas_fall_cyc = cyc;
      if (row_stb_n && col_stb_n == 2'b00) csu_run++;
      if (!row_stb_n && col_stb_n == 2'b00) chr_run++;
      if (!row_stb_n && p_row) begin
        rf_cnt++;
        chk(csu_run == CSR, "R3 column lead", csu_run, CSR);
        chk(hi_len >= RP + CSR, "R3 precharge gap", hi_len, RP + CSR);
        last_hi = hi_len; csu_run = 0; hi_len = 0; was_sr = 0;
      end
      if (!row_stb_n && col_stb_n == 2'b11 && p_col == 2'b00) begin
        chk(chr_run == CHR, "R3 column hold", chr_run, CHR);
        chr_run = 0;
      end
      if (row_stb_n) begin hi_len++; chr_run = 0; end
      if (!row_stb_n) begin
        ras_len++;
        if (sr_active) was_sr = 1;
      end
      if (row_stb_n && !p_row) begin
        if (!was_sr) chk(ras_len == RAS, "R3 row low width", ras_len, RAS);
        ras_len = 0;
      end
      p_row = row_stb_n; p_col = col_stb_n; p_req = bus_req; p_init = init_done;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; bus_gnt = 1'b1; sr_req = 1'b0; ctl_row_act = 1'b0;
    repeat (3) step();
    chk(row_stb_n == 1'b1, "R1 reset row strobe", row_stb_n, 1);
    chk(col_stb_n == 2'b11, "R1 reset column strobes", col_stb_n, 3);
    chk(bus_req == 1'b0, "R1 reset request", bus_req, 0);
    chk(init_done == 1'b0, "R1 reset init_done", init_done, 0);
    chk(sr_active == 1'b0, "R1 reset sr_active", sr_active, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_init();
    while (!init_done) step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int rf0, n;
    // Power-up and initialisation
    do_reset();
    wait_init();
    chk(first_req_cyc == PWRUP, "R1 first request clock", first_req_cyc, PWRUP);
    chk(rf_cnt == INITN, "R2 init cycle count", rf_cnt, INITN);
    chk(init_rise_cyc == PWRUP + 1 + INITN * CBR_LEN, "R2 init_done clock",
        init_rise_cyc, PWRUP + 1 + INITN * CBR_LEN);
    chk(bus_req == 1'b0, "R5 release after init", bus_req, 0);

    // Table walk: postponed refreshes (R4, R6)
    for (int i = 0; i < 4; i++) begin
      do_reset();
      wait_init();
      bus_gnt = 1'b0;
      while (!bus_req) step();
      chk(cyc - init_rise_cyc == RFSH, "R4 pacing interval", cyc - init_rise_cyc, RFSH);
      while (cyc < init_rise_cyc + POSTPONE_TBL[i][0] * RFSH + 50) step();
      chk(row_stb_n == 1'b1 && col_stb_n == 2'b11, "R5 idle without grant",
          {row_stb_n, col_stb_n}, 7);
      rf0 = rf_cnt;
      bus_gnt = 1'b1;
      step();
      while (bus_req) step();
      chk(rf_cnt - rf0 == POSTPONE_TBL[i][1], "R6 back-to-back burst",
          rf_cnt - rf0, POSTPONE_TBL[i][1]);
    end

    // Self-refresh, early drop (R7, R8)
    do_reset();
    wait_init();
    repeat (5) step();
    sr_req = 1'b1;
    while (!sr_active) step();
    chk(row_stb_n == 1'b0 && col_stb_n == 2'b00, "R7 strobes low in self-refresh",
        {row_stb_n, col_stb_n}, 0);
    sr_req = 1'b0;
    rf0 = rf_cnt;
    n = 0;
    while (sr_active) begin n++; step(); end
    chk(n == SRMIN, "R7 minimum hold", n, SRMIN);
    chk(row_stb_n == 1'b1 && col_stb_n == 2'b11, "R8 exit precharge level",
        {row_stb_n, col_stb_n}, 7);
    while (bus_req) step();
    chk(rf_cnt - rf0 == 1, "R8 one catch-up cycle", rf_cnt - rf0, 1);
    chk(last_hi == SRX + CSR, "R8 exit precharge length", last_hi, SRX + CSR);
    while (!bus_req) step();
    chk(req_rise_cyc - cas_fall_cyc == RFSH, "R8 pacing restart",
        req_rise_cyc - cas_fall_cyc, RFSH);
    while (bus_req) step();

    // Self-refresh, long hold (R7)
    sr_req = 1'b1;
    while (!sr_active) step();
    rf0 = rf_cnt;
    repeat (250) step();
    chk(sr_active == 1'b1, "R7 hold while requested", sr_active, 1);
    sr_req = 1'b0;
    while (sr_active) step();
    chk(rf_cnt == rf0, "R7 no row fall in self-refresh", rf_cnt - rf0, 0);
    while (bus_req) step();

    // Re-initialisation after a long quiet period (R9)
    do_reset();
    wait_init();
    bus_gnt = 1'b0;
    repeat (IDLE + 100) step();
    chk(init_done == 1'b0, "R9 init_done dropped", init_done, 0);
    rf0 = rf_cnt;
    bus_gnt = 1'b1;
    while (!init_done) step();
    chk(rf_cnt - rf0 == INITN, "R9 init cycles repeated", rf_cnt - rf0, INITN);
    while (bus_req) step();

    // Access-controller activity keeps the memory initialised (R10)
    do_reset();
    wait_init();
    bus_gnt = 1'b0;
    for (int k = 0; k < 3; k++) begin
      repeat (400) step();
      ctl_row_act = 1'b1;
      step();
      ctl_row_act = 1'b0;
    end
    chk(init_done == 1'b1, "R10 activity keeps init", init_done, 1);
    bus_gnt = 1'b1;
    step();
    while (bus_req) step();
    chk(init_done == 1'b1, "R10 still initialised after burst", init_done, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule